// File: doc/BRIEF.md
# Received Cell Tally with Rollover Service Requests

This block keeps received-cell statistics for a cell reassembly engine. Every cell strobe carries a channel index and a discard flag. Each strobe advances one global counter and the counter of the strobe's channel. The channel counters sit in a small internal array indexed by channel. They are updated by one read-modify-write, one clock after the strobe. The discard flag has no effect on counting: a cell that reassembly later throws away is still tallied.

When any counter wraps from all-ones to zero, a sticky status bit is set. Software clears that bit by writing a one to it. The global rollover has its own service enable. All channel rollovers share a second enable. The host request line is high while any enabled status bit is pending. A service-channel register records the channel whose wrap started the current batch of pending channel rollovers. A simple register port reads the counters, status bits, enables and service channel. Writing to a counter address clears that counter. The block accepts at most one cell strobe every two clocks.

Top module: `rx_cell_tally`

## Requirements
- R1: The global counter (address 0x00, CNT_W bits, zero-extended on reads) increments by one on the clock edge that samples `cell_vld` high.
- R2: `cell_drop` has no effect on any counter: discarded cells are counted exactly like kept ones.
- R3: When the global counter wraps from all-ones to zero, global status (address 0x01, bit 0) becomes 1. It stays 1 until a write to address 0x01 with data bit 0 set.
- R4: `host_irq` is 1 exactly when (global status AND enable bit 0) OR (any channel status bit AND enable bit 1). The enable register is address 0x03, bits [1:0], read/write.
- R5: The counter of channel c (address 0x10+c) increments by one for each cell with `cell_chan`=c. It is updated one clock after the global counter.
- R6: When channel c's counter wraps, bit c of the channel status register (address 0x02) becomes 1. Writing data with bit c set to address 0x02 clears that bit.
- R7: On a channel wrap, the service channel register (address 0x04) is loaded with c only if no channel status bit was set at that moment. Otherwise it keeps its value, and the request stays high while any enabled channel status bit remains.
- R8: A write that clears a status bit in the same cycle as a rollover that sets that bit leaves the bit set.
- R9: After reset, all counters, status bits, enables and the service channel read as zero, and `host_irq` is 0.
- R10: A write of any data to a counter address sets that counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_vld | input | 1 | Cell strobe, at most one every two clocks |
| cell_chan | input | CW | Channel index of the cell |
| cell_drop | input | 1 | Cell will be discarded downstream (does not affect counting) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (read and write) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| host_irq | output | 1 | Service request to the host |

## Verification
Cells are spread over all channels with the discard flag both set and clear. This tells a correct per-channel index apart from crossed channels, and shows whether dropped cells are skipped. Single channels are then driven across a wrap with both enables off, then with each enable on. This separates the sticky status from the enable gating of the request. A second channel wraps while the first is still pending, which shows whether the service channel is held or overwritten. A clearing write lands on the exact edge of a global wrap, which checks that the set takes priority.

// File: rtl/rct_pkg.sv
package rct_pkg;
   localparam int unsigned REG_AW   = 5;
   localparam logic [REG_AW-1:0] A_CELLS  = 5'h00;
   localparam logic [REG_AW-1:0] A_GSTAT  = 5'h01;
   localparam logic [REG_AW-1:0] A_CSTAT  = 5'h02;
   localparam logic [REG_AW-1:0] A_SVCEN  = 5'h03;
   localparam logic [REG_AW-1:0] A_SVCCH  = 5'h04;
   localparam logic [REG_AW-1:0] A_CHBASE = 5'h10;
   localparam int unsigned CH_MAX   = 16;
endpackage

// File: rtl/rct_wrap_counter.sv
module rct_wrap_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   assign wrap = inc && !clr && (cnt == {W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rct_sticky.sv
module rct_sticky #(
   parameter int unsigned N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= set[i] | (q[i] & ~clr[i]);
      end
   end
endmodule

// File: rtl/rct_chan_bank.sv
module rct_chan_bank #(
   parameter int unsigned W  = 16,
   parameter int unsigned N  = 8,
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cell_vld,
   input  logic [CW-1:0] cell_chan,
   input  logic          sw_clr,
   input  logic [CW-1:0] sw_chan,
   input  logic [CW-1:0] rd_chan,
   output logic [W-1:0]  rd_cnt,
   output logic          wrap,
   output logic [CW-1:0] wrap_chan
);
   logic [W-1:0]  mem [N];
   logic          p_vld;
   logic [CW-1:0] p_chan;
   logic          p_ok;
   logic [W-1:0]  p_old;

   assign p_ok  = p_vld && (32'(p_chan) < N);
   assign p_old = p_ok ? mem[p_chan] : '0;
   assign wrap  = p_ok && (p_old == {W{1'b1}}) && !(sw_clr && sw_chan == p_chan);
   assign wrap_chan = p_chan;
   assign rd_cnt = (32'(rd_chan) < N) ? mem[rd_chan] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_vld  <= 1'b0;
         p_chan <= '0;
      end else begin
         p_vld  <= cell_vld;
         p_chan <= cell_chan;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) mem[i] <= '0;
      end else begin
         if (p_ok) mem[p_chan] <= p_old + 1'b1;
         if (sw_clr && (32'(sw_chan) < N)) mem[sw_chan] <= '0;
      end
   end
endmodule

// File: rtl/rx_cell_tally.sv
module rx_cell_tally
   import rct_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned CH_N   = 8,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned CW    = (CH_N > 1) ? $clog2(CH_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cell_vld,
   input  logic [CW-1:0]     cell_chan,
   input  logic              cell_drop,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              host_irq
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie in 2..DATA_W");
   end
   if (CH_N < 1 || CH_N > CH_MAX || CH_N > DATA_W) begin : g_bad_ch_n
      $error("CH_N must lie in 1..16 and not exceed DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data_w
      $error("DATA_W must be at least 2");
   end

   logic [REG_AW-1:0] ch_off;
   logic              ch_hit;
   logic [CW-1:0]     ch_sel;
   logic              cells_clr;
   logic              gstat_wr;
   logic              cstat_wr;
   logic [CNT_W-1:0]  g_count;
   logic              g_wrap;
   logic [CNT_W-1:0]  c_rd_cnt;
   logic              c_wrap;
   logic [CW-1:0]     c_wrap_chan;
   logic [0:0]        g_stat;
   logic [CH_N-1:0]   c_stat;
   logic [CH_N-1:0]   c_set;
   logic [1:0]        en;
   logic [CW-1:0]     svc_chan;
   logic              unused_drop;

   assign unused_drop = cell_drop;
   assign ch_off    = reg_addr - A_CHBASE;
   assign ch_hit    = (reg_addr >= A_CHBASE) && (32'(ch_off) < CH_N);
   assign ch_sel    = ch_off[CW-1:0];
   assign cells_clr = reg_we && (reg_addr == A_CELLS);
   assign gstat_wr  = reg_we && (reg_addr == A_GSTAT);
   assign cstat_wr  = reg_we && (reg_addr == A_CSTAT);

   rct_wrap_counter #(.W(CNT_W)) u_gcnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cell_vld),
      .clr  (cells_clr),
      .cnt  (g_count),
      .wrap (g_wrap)
   );

   rct_chan_bank #(.W(CNT_W), .N(CH_N), .CW(CW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cell_vld (cell_vld),
      .cell_chan(cell_chan),
      .sw_clr   (reg_we && ch_hit),
      .sw_chan  (ch_sel),
      .rd_chan  (ch_sel),
      .rd_cnt   (c_rd_cnt),
      .wrap     (c_wrap),
      .wrap_chan(c_wrap_chan)
   );

   rct_sticky #(.N(1)) u_gstat (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (g_wrap),
      .clr  (gstat_wr & reg_wdata[0]),
      .q    (g_stat)
   );

   always_comb begin
      c_set = '0;
      if (c_wrap) c_set[c_wrap_chan] = 1'b1;
   end

   rct_sticky #(.N(CH_N)) u_cstat (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (c_set),
      .clr  ({CH_N{cstat_wr}} & reg_wdata[CH_N-1:0]),
      .q    (c_stat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en       <= '0;
         svc_chan <= '0;
      end else begin
         if (reg_we && reg_addr == A_SVCEN) en <= reg_wdata[1:0];
         if (c_wrap && c_stat == '0) svc_chan <= c_wrap_chan;
      end
   end

   assign host_irq = (g_stat[0] & en[0]) | ((|c_stat) & en[1]);

   always_comb begin
      reg_rdata = '0;
      if (ch_hit) reg_rdata = DATA_W'(c_rd_cnt);
      else begin
         case (reg_addr)
            A_CELLS: reg_rdata = DATA_W'(g_count);
            A_GSTAT: reg_rdata = DATA_W'(g_stat);
            A_CSTAT: reg_rdata = DATA_W'(c_stat);
            A_SVCEN: reg_rdata = DATA_W'(en);
            A_SVCCH: reg_rdata = DATA_W'(svc_chan);
            default: reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/rct_checker.sv
module rct_checker
   import rct_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned CH_N   = 8,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CW     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cell_vld,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              host_irq,
   input logic [CNT_W-1:0]  g_count,
   input logic [0:0]        g_stat,
   input logic [CH_N-1:0]   c_stat,
   input logic [1:0]        en,
   input logic [CW-1:0]     svc_chan
);
   // R1
   a_r1_global_step: assert property (@(posedge clk) disable iff (!rst_n)
      cell_vld && !(reg_we && reg_addr == A_CELLS) |=> g_count == $past(g_count) + 1'b1);

   // R3
   a_r3_global_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      g_stat[0] && !(reg_we && reg_addr == A_GSTAT && reg_wdata[0]) |=> g_stat[0]);

   // R4
   a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      en == 2'b00 |-> !host_irq);

   // R7
   a_r7_svc_held: assert property (@(posedge clk) disable iff (!rst_n)
      c_stat != '0 |=> $stable(svc_chan));

   // R7
   a_r7_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
      en[1] && c_stat != '0 |-> host_irq);

   // R8
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cell_vld && g_count == {CNT_W{1'b1}} && !(reg_we && reg_addr == A_CELLS) |=> g_stat[0]);
endmodule

bind rx_cell_tally rct_checker #(
   .CNT_W(CNT_W), .CH_N(CH_N), .DATA_W(DATA_W), .CW(CW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cell_vld (cell_vld),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .host_irq (host_irq),
   .g_count  (g_count),
   .g_stat   (g_stat),
   .c_stat   (c_stat),
   .en       (en),
   .svc_chan (svc_chan)
);

// File: tb/sim_rx_cell_tally.sv
module sim_rx_cell_tally;
   localparam int CNT_W = 5;
   localparam int CH_N  = 8;
   localparam int CW    = 3;
   localparam int MASK  = (1 << CNT_W) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cell_vld = 1'b0;
   logic [2:0]  cell_chan = '0;
   logic        cell_drop = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        host_irq;

   always #2 clk = ~clk;

   rx_cell_tally #(.CNT_W(CNT_W), .CH_N(CH_N), .DATA_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_chan(cell_chan),
      .cell_drop(cell_drop), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq));

   typedef struct {
      bit          is_irq;
      logic [15:0] exp;
      string       req;
   } item_t;
   item_t sb[$];

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model
   int gcnt;
   int ccnt [CH_N];
   bit gst;
   logic [CH_N-1:0] cst;
   logic [1:0] en_m;
   int svc;

   function automatic bit model_irq();
      return (gst & en_m[0]) | ((|cst) & en_m[1]);
   endfunction

   // monitor: compares queued expectations against the design
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [15:0] act;
         it = sb.pop_front();
         act = it.is_irq ? {15'd0, host_irq} : reg_rdata;
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", it.req, act, it.exp);
         end
      end
   end

   task automatic exp_reg(input logic [4:0] a, input int v, input string req);
      @(posedge clk); #1;
      reg_addr = a;
      sb.push_back('{1'b0, 16'(v), req});
   endtask

   task automatic exp_irq(input string req);
      @(posedge clk); #1;
      sb.push_back('{1'b1, {15'd0, model_irq()}, req});
   endtask

   task automatic model_cell(input int ch);
      if (gcnt == MASK) gst = 1;
      gcnt = (gcnt + 1) & MASK;
      if (ccnt[ch] == MASK) begin
         if (cst == '0) svc = ch;
         cst[ch] = 1'b1;
      end
      ccnt[ch] = (ccnt[ch] + 1) & MASK;
   endtask

   task automatic model_write(input logic [4:0] a, input int d);
      if (a == 5'h00) gcnt = 0;
      else if (a == 5'h01) begin if (d & 1) gst = 0; end
      else if (a == 5'h02) cst = cst & ~CH_N'(d);
      else if (a == 5'h03) en_m = 2'(d);
      else if (a >= 5'h10 && a < 5'h10 + CH_N) ccnt[a - 5'h10] = 0;
   endtask

   task automatic send_cell(input int ch, input bit drop);
      @(posedge clk); #1;
      cell_vld = 1'b1; cell_chan = 3'(ch); cell_drop = drop;
      @(posedge clk); #1;
      cell_vld = 1'b0; cell_drop = 1'b0;
      @(posedge clk); #1;
      model_cell(ch);
   endtask

   task automatic reg_write(input logic [4:0] a, input int d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = 16'(d);
      @(posedge clk); #1;
      reg_we = 1'b0;
      model_write(a, d);
   endtask

   task automatic check_all(input string req);
      exp_reg(5'h00, gcnt, req);
      exp_reg(5'h01, int'(gst), req);
      exp_reg(5'h02, int'(cst), req);
      exp_reg(5'h03, int'(en_m), req);
      exp_reg(5'h04, svc, req);
      for (int c = 0; c < CH_N; c++) exp_reg(5'(16 + c), ccnt[c], req);
      exp_irq(req);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      gcnt = 0; gst = 0; cst = '0; en_m = '0; svc = 0;
      for (int c = 0; c < CH_N; c++) ccnt[c] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9: reset state
      check_all("R9 reset");

      // R1 R2 R5: mixed channels and discard flags
      for (int i = 0; i < 20; i++) send_cell((i * 3) % CH_N, bit'(i % 2));
      check_all("R1 R2 R5 mixed cells");
      for (int i = 0; i < 6; i++) send_cell(2, 1'b1);
      exp_reg(5'h12, ccnt[2], "R2 dropped cells counted");

      // R6 R4: channel 3 wraps with enables off
      while (ccnt[3] != MASK) send_cell(3, 1'b0);
      exp_reg(5'h02, int'(cst), "R6 before wrap");
      send_cell(3, 1'b1);
      exp_reg(5'h02, int'(cst), "R6 status after wrap");
      exp_reg(5'h13, 0, "R5 counter wrapped to zero");
      exp_reg(5'h04, 3, "R7 service channel captured");
      exp_irq("R4 no request while disabled");

      // R4 R7: enable channel requests; second wrap keeps service channel
      reg_write(5'h03, 2);
      exp_irq("R4 request with channel enable");
      while (ccnt[5] != MASK) send_cell(5, 1'b0);
      send_cell(5, 1'b0);
      exp_reg(5'h02, int'(cst), "R6 second channel status");
      exp_reg(5'h04, 3, "R7 service channel held");
      reg_write(5'h02, 1 << 3);
      exp_reg(5'h02, int'(cst), "R6 clear one bit");
      exp_irq("R7 request still pending");
      reg_write(5'h02, 1 << 5);
      exp_irq("R7 request drops when all clear");
      while (ccnt[6] != MASK) send_cell(6, 1'b1);
      send_cell(6, 1'b0);
      exp_reg(5'h04, 6, "R7 new capture after clear");
      reg_write(5'h02, 16'hffff);

      // R3 R4: global wrap
      while (gcnt != MASK) send_cell(0, 1'b0);
      send_cell(1, 1'b0);
      exp_reg(5'h01, 1, "R3 global status set");
      exp_reg(5'h00, gcnt, "R1 global wrapped");
      exp_irq("R4 global disabled");
      reg_write(5'h03, 1);
      exp_irq("R4 global enabled");
      reg_write(5'h01, 0);
      exp_reg(5'h01, 1, "R3 write of zero keeps status");
      reg_write(5'h01, 1);
      exp_reg(5'h01, 0, "R3 status cleared");
      exp_irq("R4 global cleared");

      // R8: clear and rollover on the same edge
      while (gcnt != MASK) send_cell(4, 1'b0);
      @(posedge clk); #1;
      cell_vld = 1'b1; cell_chan = 3'd4;
      reg_we = 1'b1; reg_addr = 5'h01; reg_wdata = 16'h0001;
      @(posedge clk); #1;
      cell_vld = 1'b0; reg_we = 1'b0;
      @(posedge clk); #1;
      model_write(5'h01, 1);
      model_cell(4);
      exp_reg(5'h01, 1, "R8 set wins over clear");

      // R10: software clears counters
      send_cell(7, 1'b0);
      reg_write(5'h17, 16'h1234);
      exp_reg(5'h17, 0, "R10 channel counter cleared");
      reg_write(5'h00, 16'h00ff);
      exp_reg(5'h00, 0, "R10 global counter cleared");
      check_all("R10 final state");

      repeat (2) @(posedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule